// File: doc/BRIEF.md
# Bit-Bang SPI Port

This block lets software run an SPI link by hand. A small 32-bit register bus reaches four words: a function-select word, a free control word, a pin-drive word and a capture word. When the function-select enable bit is set, the pin-drive word sets the serial clock, the data-out line and three chip-select lines directly. Software makes each clock edge itself by rewriting the pin-drive word. When the enable bit is clear, the pins are handed to a memory-mapped read engine that lies outside this block, and its signals pass straight through.

Each rising clock edge that software writes in manual mode takes one bit from the data-in pin into a 32-bit shift register. The newest bit goes into bit 0. Software reads this shift register back after a word has been clocked. The data-in pin passes through a short synchronizer first, so software must let a few bus cycles pass between a data-in change and the clock edge that samples it. Chip-select polarity is not handled in hardware: each select pin shows the written bit level unchanged.

Top module: `bbspi_port`

## Requirements
- R1: After reset, function select reads 0, control reads 0, the capture word reads 0, and the pin-drive word reads 0x0007_0000: all three selects high, clock and data-out low.
- R2: The function-select word is at byte offset 0x00. Only bit 0 (manual enable) is stored; every other bit reads as 0.
- R3: While manual enable is 1, one cycle after a write to the pin-drive word at 0x08, spi_mosi equals bit 0, spi_sclk equals bit 8, and spi_cs[k] equals bit 16+k for k = 0..2.
- R4: While manual enable is 0, spi_sclk, spi_mosi and spi_cs follow eng_sclk, eng_mosi and eng_cs in the same cycle.
- R5: The control word at 0x04 is a plain 32-bit read/write register. For example, 0x43 written reads back as 0x43.
- R6: The pin-drive word keeps only bits 0, 8 and 16..18. A read returns those bits and zeros everywhere else.
- R7: A pin-drive write made in manual mode that takes bit 8 from 0 to 1 shifts the synchronized data-in value into bit 0 of the capture word at 0x0C. The older bits move up one place, and only the last 32 bits are kept.
- R8: A pin-drive write that leaves the clock bit unchanged or takes it from 1 to 0 does not change the capture word. Reading the capture word does not clear it.
- R9: A clock-bit rise written while manual enable is 0 captures nothing.
- R10: Only the word-aligned offsets 0x00, 0x04, 0x08 and 0x0C are mapped; offsets 0x01–0x03, 0x05–0x07, 0x09–0x0B, 0x0D–0x0F and 0x10–0x1F are unmapped. Reads there return 0 and writes there change nothing. The capture word is read-only, so writes to 0x0C are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 5 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_sclk | input | 1 | Read engine serial clock |
| eng_mosi | input | 1 | Read engine data-out |
| eng_cs | input | 3 | Read engine chip selects |
| spi_miso | input | 1 | Serial data-in pin |
| spi_sclk | output | 1 | Serial clock pin |
| spi_mosi | output | 1 | Serial data-out pin |
| spi_cs | output | 3 | Chip-select pins, level as written |

## Verification
Suppose the stored clock bit disagrees with the last written value. The error then shows in two places: spi_sclk is wrong one cycle after the write, and the capture word either misses or duplicates bits. Both are visible the next time that word is read. A shift path that drops, reorders or clears bits shows up as a wrong capture word after a known multi-bit pattern, including a pattern longer than 32 bits. A decode fault shows as a register that changes after a write to an unmapped offset, or as a nonzero read from one. A mux fault shows as the pins failing to follow the engine inputs in the same cycle while manual mode is off.

// File: rtl/bbspi_pkg.sv
// Package: shared offsets, bit positions and decode helper for the bit-bang SPI port.
// Assumes byte addressing with 32-bit words; only aligned offsets decode.
package bbspi_pkg;

    localparam int unsigned OFS_FSEL  = 0;
    localparam int unsigned OFS_CTRL  = 4;
    localparam int unsigned OFS_PINS  = 8;
    localparam int unsigned OFS_SHIFT = 12;

    localparam int unsigned PIN_MOSI_BIT = 0;
    localparam int unsigned PIN_SCLK_BIT = 8;
    localparam int unsigned PIN_CS_LSB   = 16;

    typedef enum logic [1:0] {
        SEL_FSEL  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_PINS  = 2'd2,
        SEL_SHIFT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    // Map a byte offset to a register select; unaligned or out-of-range misses.
    function automatic reg_dec_t decode_ofs(input logic [31:0] ofs);
        reg_dec_t d;
        d.hit = 1'b0;
        d.sel = SEL_FSEL;
        if (ofs[1:0] == 2'b00 && ofs < 32'd16) begin
            d.hit = 1'b1;
            d.sel = reg_sel_e'(ofs[3:2]);
        end
        return d;
    endfunction

endpackage

// File: rtl/bbspi_sync.sv
// Module: bbspi_sync
// Brings the asynchronous data-in pin into the clock domain through STAGES flops.
// Assumes the pin is held stable for more than STAGES cycles before it is sampled.
module bbspi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;

            // Shift the pin value through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else if (STAGES == 1) begin
                    chain_q[0] <= d;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], d};
                end
            end

            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bbspi_regs.sv
// Module: bbspi_regs
// Register file: function select, control, pin-drive word and read mux of the capture word.
// Also flags a software-written rising clock edge in manual mode.
// Assumes single-cycle writes and combinational reads without side effects.
module bbspi_regs
    import bbspi_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned NUM_CS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] shift_val,
    output logic [DATA_W-1:0] rdata,
    output logic              manual,
    output logic              pin_mosi,
    output logic              pin_sclk,
    output logic [NUM_CS-1:0] pin_cs,
    output logic              sclk_rise
);

    localparam int unsigned CS_MSB = PIN_CS_LSB + NUM_CS - 1;

    reg_dec_t          dec;
    logic              wr_fsel;
    logic              wr_ctrl;
    logic              wr_pins;
    logic              fsel_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              mosi_q;
    logic              sclk_q;
    logic [NUM_CS-1:0] cs_q;
    logic [DATA_W-1:0] pins_img;

    assign dec     = decode_ofs(32'(addr));
    assign wr_fsel = wr_en && dec.hit && (dec.sel == SEL_FSEL);
    assign wr_ctrl = wr_en && dec.hit && (dec.sel == SEL_CTRL);
    assign wr_pins = wr_en && dec.hit && (dec.sel == SEL_PINS);

    // Hold the manual-mode enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsel_q <= 1'b0;
        end else if (wr_fsel) begin
            fsel_q <= wdata[0];
        end
    end

    // Hold the free-form control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    // Hold the pin-drive bits; selects reset high, clock and data-out low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mosi_q <= 1'b0;
            sclk_q <= 1'b0;
            cs_q   <= '1;
        end else if (wr_pins) begin
            mosi_q <= wdata[PIN_MOSI_BIT];
            sclk_q <= wdata[PIN_SCLK_BIT];
            cs_q   <= wdata[CS_MSB:PIN_CS_LSB];
        end
    end

    // Flag a manual-mode write that raises the clock bit.
    assign sclk_rise = wr_pins && fsel_q && wdata[PIN_SCLK_BIT] && !sclk_q;

    // Assemble the read image of the pin-drive word.
    always_comb begin
        pins_img = '0;
        pins_img[PIN_MOSI_BIT] = mosi_q;
        pins_img[PIN_SCLK_BIT] = sclk_q;
        for (int k = 0; k < int'(NUM_CS); k++) begin
            pins_img[PIN_CS_LSB + k] = cs_q[k];
        end
    end

    // Select read data by decoded offset; misses return zero.
    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_FSEL:  rdata = {{(DATA_W-1){1'b0}}, fsel_q};
                SEL_CTRL:  rdata = ctrl_q;
                SEL_PINS:  rdata = pins_img;
                SEL_SHIFT: rdata = shift_val;
                default:   rdata = '0;
            endcase
        end
    end

    assign manual   = fsel_q;
    assign pin_mosi = mosi_q;
    assign pin_sclk = sclk_q;
    assign pin_cs   = cs_q;

    // Leaving reset, the pin-drive word holds its idle value.
    p_pins_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cs_q == '1 && !sclk_q && !mosi_q && !fsel_q))
        else $error("pin-drive reset value wrong");

    // Unmapped writes leave every stored register untouched.
    p_unmapped_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dec.hit) |=> ($stable(fsel_q) && $stable(ctrl_q)
                                 && $stable(cs_q) && $stable(sclk_q) && $stable(mosi_q)))
        else $error("unmapped write changed a register");

    // Only bit 0 of function select is ever visible.
    p_fsel_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.hit && dec.sel == SEL_FSEL) |-> (rdata[DATA_W-1:1] == '0))
        else $error("function select upper bits nonzero");

endmodule

// File: rtl/bbspi_capture.sv
// Module: bbspi_capture
// Capture shift register: on each flagged clock rise, shifts the synchronized data-in bit
// into bit 0. Assumes the flag is only raised in manual mode; never cleared by a read.
module bbspi_capture #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              din,
    output logic [DATA_W-1:0] shreg
);

    logic [DATA_W-1:0] shreg_q;

    // Shift left and insert the sampled bit on a software clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (rise) begin
            shreg_q <= {shreg_q[DATA_W-2:0], din};
        end
    end

    assign shreg = shreg_q;

    // A rise moves the old contents up one place and inserts the sampled bit.
    p_shift_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (shreg_q[DATA_W-1:1] == $past(shreg_q[DATA_W-2:0])
                  && shreg_q[0] == $past(din)))
        else $error("capture shift wrong");

    // Without a rise the captured bits hold.
    p_hold_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(shreg_q))
        else $error("capture changed without a clock rise");

endmodule

// File: rtl/bbspi_pinmux.sv
// Module: bbspi_pinmux
// Pin ownership select: manual mode drives the pins from the pin-drive word,
// otherwise the external read engine owns them. Purely combinational.
module bbspi_pinmux #(
    parameter int unsigned NUM_CS = 3
) (
    input  logic              manual,
    input  logic              pin_mosi,
    input  logic              pin_sclk,
    input  logic [NUM_CS-1:0] pin_cs,
    input  logic              eng_mosi,
    input  logic              eng_sclk,
    input  logic [NUM_CS-1:0] eng_cs,
    output logic              out_mosi,
    output logic              out_sclk,
    output logic [NUM_CS-1:0] out_cs
);

    // Route serial clock and data-out from the current owner.
    always_comb begin
        out_mosi = manual ? pin_mosi : eng_mosi;
        out_sclk = manual ? pin_sclk : eng_sclk;
    end

    generate
        for (genvar k = 0; k < int'(NUM_CS); k++) begin : g_cs
            // Route chip select k from the current owner.
            assign out_cs[k] = manual ? pin_cs[k] : eng_cs[k];
        end
    endgenerate

endmodule

// File: rtl/bbspi_port.sv
// Module: bbspi_port (top)
// Register-driven SPI port: software toggles pins through a register word, and the block
// captures data-in on software-made clock rises. Assumes a simple single-cycle bus.
module bbspi_port
    import bbspi_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned NUM_CS      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_sclk,
    input  logic              eng_mosi,
    input  logic [NUM_CS-1:0] eng_cs,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs
);

    logic              miso_s;
    logic              manual;
    logic              pin_mosi;
    logic              pin_sclk;
    logic [NUM_CS-1:0] pin_cs;
    logic              sclk_rise;
    logic [DATA_W-1:0] shreg;

    bbspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (spi_miso),
        .q     (miso_s)
    );

    bbspi_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .shift_val (shreg),
        .rdata     (bus_rdata),
        .manual    (manual),
        .pin_mosi  (pin_mosi),
        .pin_sclk  (pin_sclk),
        .pin_cs    (pin_cs),
        .sclk_rise (sclk_rise)
    );

    bbspi_capture #(.DATA_W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (sclk_rise),
        .din   (miso_s),
        .shreg (shreg)
    );

    bbspi_pinmux #(.NUM_CS(NUM_CS)) u_pinmux (
        .manual   (manual),
        .pin_mosi (pin_mosi),
        .pin_sclk (pin_sclk),
        .pin_cs   (pin_cs),
        .eng_mosi (eng_mosi),
        .eng_sclk (eng_sclk),
        .eng_cs   (eng_cs),
        .out_mosi (spi_mosi),
        .out_sclk (spi_sclk),
        .out_cs   (spi_cs)
    );

    // A manual-mode pin-drive write shows its clock bit on the pin next cycle.
    p_sclk_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(OFS_PINS) && manual)
            |=> (spi_sclk == $past(bus_wdata[PIN_SCLK_BIT])))
        else $error("serial clock pin does not follow written bit");

    // When function select reads back 0, the selects follow the engine.
    p_engine_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_FSEL) && !bus_rdata[0]) |-> (spi_cs == eng_cs))
        else $error("selects not owned by engine in engine mode");

    // With manual enable clear, no capture is ever flagged.
    p_no_capture_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !manual |-> !sclk_rise)
        else $error("capture flagged outside manual mode");

endmodule

// File: tb/bbspi_port_bench.sv
// Directed bench for bbspi_port: one task per scenario, each checking its own results.
module bbspi_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_sclk = 1'b0;
    logic        eng_mosi = 1'b0;
    logic [2:0]  eng_cs = 3'b000;
    logic        spi_miso = 1'b0;
    logic        spi_sclk;
    logic        spi_mosi;
    logic [2:0]  spi_cs;

    int          total = 0;
    int          bad = 0;
    logic [31:0] exp_shift = '0;
    logic [31:0] rd;

    bbspi_port u_bbspi_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_sclk  (eng_sclk),
        .eng_mosi  (eng_mosi),
        .eng_cs    (eng_cs),
        .spi_miso  (spi_miso),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_cs    (spi_cs)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] pin_word(input logic [2:0] cs, input logic sclk,
                                             input logic mosi);
        return {13'd0, cs, 7'd0, sclk, 7'd0, mosi};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rdw(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_addr  = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pins_now(output logic [31:0] p);
        #1;
        p = {27'd0, spi_cs, spi_sclk, spi_mosi};
    endtask

    task automatic t_reset;
        logic [31:0] p;
        rdw(5'h00, rd); chk("R1 fsel", rd, 32'h0);
        rdw(5'h04, rd); chk("R1 ctrl", rd, 32'h0);
        rdw(5'h08, rd); chk("R1 pins word", rd, 32'h0007_0000);
        rdw(5'h0C, rd); chk("R1 shift", rd, 32'h0);
        eng_cs = 3'b101; eng_sclk = 1'b1; eng_mosi = 1'b0;
        pins_now(p); chk("R4 engine pins a", p, {27'd0, 3'b101, 1'b1, 1'b0});
        eng_cs = 3'b010; eng_sclk = 1'b0; eng_mosi = 1'b1;
        pins_now(p); chk("R4 engine pins b", p, {27'd0, 3'b010, 1'b0, 1'b1});
    endtask

    task automatic t_ctrl;
        wr(5'h04, 32'h0000_0043);
        rdw(5'h04, rd); chk("R5 ctrl 0x43", rd, 32'h43);
        wr(5'h04, 32'hA5C3_5A3C);
        rdw(5'h04, rd); chk("R5 ctrl pattern", rd, 32'hA5C3_5A3C);
    endtask

    task automatic t_manual;
        logic [31:0] p;
        wr(5'h00, 32'hFFFF_FFFF);
        rdw(5'h00, rd); chk("R2 fsel only bit0", rd, 32'h1);
        pins_now(p); chk("R3 idle pins", p, {27'd0, 3'b111, 1'b0, 1'b0});
        wr(5'h08, 32'hFFFF_FEFE);
        rdw(5'h08, rd); chk("R6 pins mask a", rd, 32'h0007_0000);
        wr(5'h08, pin_word(3'b010, 1'b0, 1'b1) | 32'hF0F0_00F0);
        rdw(5'h08, rd); chk("R6 pins mask b", rd, pin_word(3'b010, 1'b0, 1'b1));
        pins_now(p); chk("R3 pins follow word", p, {27'd0, 3'b010, 1'b0, 1'b1});
        wr(5'h08, pin_word(3'b110, 1'b0, 1'b0));
    endtask

    task automatic xfer(input logic [63:0] din, input logic [63:0] dout, input int n);
        logic [31:0] p;
        for (int i = n - 1; i >= 0; i--) begin
            spi_miso = din[i];
            wr(5'h08, pin_word(3'b110, 1'b0, dout[i]));
            repeat (3) @(negedge clk);
            wr(5'h08, pin_word(3'b110, 1'b1, dout[i]));
            exp_shift = {exp_shift[30:0], din[i]};
            pins_now(p);
            chk("R3 pins during bit", p, {27'd0, 3'b110, 1'b1, dout[i]});
        end
        wr(5'h08, pin_word(3'b110, 1'b0, 1'b0));
    endtask

    task automatic t_byte;
        xfer(64'hB4, 64'h5A, 8);
        rdw(5'h0C, rd); chk("R7 byte captured", rd, exp_shift);
        rdw(5'h0C, rd); chk("R8 read does not clear", rd, exp_shift);
    endtask

    task automatic t_no_shift;
        spi_miso = 1'b1;
        repeat (4) @(negedge clk);
        wr(5'h08, pin_word(3'b110, 1'b1, 1'b0));
        exp_shift = {exp_shift[30:0], 1'b1};
        wr(5'h08, pin_word(3'b110, 1'b1, 1'b1));
        rdw(5'h0C, rd); chk("R8 clock held high no shift", rd, exp_shift);
        wr(5'h08, pin_word(3'b110, 1'b0, 1'b0));
        wr(5'h08, pin_word(3'b011, 1'b0, 1'b1));
        rdw(5'h0C, rd); chk("R8 fall and low writes no shift", rd, exp_shift);
    endtask

    task automatic t_long;
        xfer(64'h9_A5C3_E17B, 64'h0, 36);
        rdw(5'h0C, rd); chk("R7 last 32 of 36 bits", rd, 32'hA5C3_E17B);
        chk("R7 model agrees", exp_shift, 32'hA5C3_E17B);
    endtask

    task automatic t_engine_mode;
        logic [31:0] p;
        wr(5'h00, 32'h0);
        spi_miso = 1'b1;
        repeat (4) @(negedge clk);
        wr(5'h08, pin_word(3'b001, 1'b1, 1'b1));
        wr(5'h08, pin_word(3'b001, 1'b0, 1'b1));
        eng_cs = 3'b100; eng_sclk = 1'b1; eng_mosi = 1'b0;
        pins_now(p); chk("R4 engine owns pins", p, {27'd0, 3'b100, 1'b1, 1'b0});
        wr(5'h00, 32'h1);
        rdw(5'h0C, rd); chk("R9 no capture in engine mode", rd, exp_shift);
        pins_now(p); chk("R3 stored word on reentry", p, {27'd0, 3'b001, 1'b0, 1'b1});
    endtask

    task automatic t_unmapped;
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h06, 32'hFFFF_FFFF);
        wr(5'h0A, 32'h0000_0000);
        wr(5'h0C, 32'h1234_5678);
        rdw(5'h00, rd); chk("R10 fsel kept", rd, 32'h1);
        rdw(5'h04, rd); chk("R10 ctrl kept", rd, 32'hA5C3_5A3C);
        rdw(5'h08, rd); chk("R10 pins kept", rd, pin_word(3'b001, 1'b0, 1'b1));
        rdw(5'h0C, rd); chk("R10 shift read-only", rd, exp_shift);
        rdw(5'h10, rd); chk("R10 read 0x10 zero", rd, 32'h0);
        rdw(5'h1C, rd); chk("R10 read 0x1C zero", rd, 32'h0);
        rdw(5'h05, rd); chk("R10 unaligned read zero", rd, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_manual();
        t_byte();
        t_no_shift();
        t_long();
        t_engine_mode();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule